// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block sits on the management side of a switch device whose registers are reached through a small window of 16-bit management registers. It takes one request and runs the access to completion. A request names a page, a register inside that page, a byte length, a direction and up to 64 bits of write data. The block opens the window for the page and moves the data words through the data registers. It starts the operation, polls for completion with a bounded retry count, and then closes the window.

The downstream side is an abstract 16-bit register port. The block raises a write or read strobe together with a 5-bit register address and write data. It holds all of them until the port answers with `bus_ready`, and read data is taken in the same cycle. The serial management waveform lives behind that port. The block pulses `done` once for every request it accepts. It reports a rejected length on `len_err` and a poll timeout on `timeout`, and it returns read data on `rsp_rdata`. These three outputs are valid from the `done` pulse until the next request is accepted.

Top module: `paged_reg_seq`

## Requirements
- R1: A request (`req_valid` high at a clock edge) is taken only while `busy` is low. `busy` stays high from the edge after acceptance until the window is closed. A request raised while `busy` is high causes no bus access of its own.
- R2: A request whose length is not 1, 2, 4, 6 or 8 produces `done` and `len_err` in the next cycle. It raises no bus strobe and `busy` stays low.
- R3: The first access of every accepted request writes register 16 with the page in bits 15:8 and 0x01 in bits 7:0 (window enable).
- R4: A write request sends its data words to registers 24, 25, 26 and 27 in ascending order. Register 24+k carries bits 16k+15:16k, and the number of words is 1 for lengths 1 and 2, otherwise length/2. For length 1 the upper byte sent is zero. The data is followed by a write to register 17 of the register number in bits 15:8, zeros in bits 7:2 and 01 in bits 1:0.
- R5: A read request writes register 17 right after the window opens. The value is the register number in bits 15:8, zeros in bits 7:2 and 10 in bits 1:0.
- R6: After the command, register 17 is read until bits 1:0 read back as 00. Between two consecutive polls the block waits at least WAIT_CYCLES clock cycles.
- R7: If POLL_LIMIT polls all read back a nonzero value in bits 1:0, `timeout` is set and the window is closed. On a read, no data register is accessed and `rsp_rdata` is zero.
- R8: On a successful read, data registers are read from the highest down to 24 for lengths 6 and 8, and from 24 upward for lengths 2 and 4. Length 1 reads only register 24.
- R9: The word read from register 24+k lands in `rsp_rdata` bits 16k+15:16k. For length 1 only bits 7:0 are filled. All bits above the requested length are zero.
- R10: Every accepted request ends with a write of register 16 with the page in bits 15:8 and 0x00 in bits 7:0. `done` pulses for exactly one cycle after that write completes.
- R11: `bus_wr` and `bus_rd` are never high together. While a strobe waits for `bus_ready`, the strobe, address and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 8 | Register page |
| req_reg | input | 8 | Register number within the page |
| req_len | input | 4 | Length in bytes |
| req_wdata | input | 64 | Write data, least significant word first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| len_err | output | 1 | Last request rejected for its length |
| timeout | output | 1 | Last request ran out of polls |
| rsp_rdata | output | 64 | Read data of the last request |
| bus_addr | output | 5 | Management register address |
| bus_wdata | output | 16 | Management write data |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_rdata | input | 16 | Management read data, valid with ready |
| bus_ready | input | 1 | Transfer completes at this edge |

## Verification
Some properties are checked on every cycle. These are the port discipline (exclusive strobes, held address and data, no strobe while idle, only window, command and data registers addressed), the legal opcodes in command writes, the one-cycle `done`, the immediate rejection of bad lengths and the absence of data reads once a timeout is flagged. The order of accesses inside a sequence can only be shown by the bench's scenarios, which log every transfer the port model completes. So can the placement of words, the descending order for long reads, the spacing of polls, the count of polls before a timeout and the assembled read data.

// File: rtl/paged_reg_seq.sv
module paged_reg_seq #(
  parameter int POLL_LIMIT  = 5,
  parameter int WAIT_CYCLES = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_page,
  input  logic [7:0]  req_reg,
  input  logic [3:0]  req_len,
  input  logic [63:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        len_err,
  output logic        timeout,
  output logic [63:0] rsp_rdata,
  output logic [4:0]  bus_addr,
  output logic [15:0] bus_wdata,
  output logic        bus_wr,
  output logic        bus_rd,
  input  logic [15:0] bus_rdata,
  input  logic        bus_ready
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam int WCW = $clog2(WAIT_CYCLES + 1);
  localparam logic [4:0] A_WIN  = 5'd16;
  localparam logic [4:0] A_CMD  = 5'd17;
  localparam logic [4:0] A_DATA = 5'd24;

  typedef enum logic [2:0] {S_IDLE, S_OPEN, S_WDAT, S_CMD, S_POLL, S_WAIT, S_RDAT, S_CLOSE} st_t;

  st_t         st;
  logic        wr_q;
  logic [7:0]  page_q, reg_q;
  logic [3:0]  len_q;
  logic [63:0] wdata_q;
  logic [1:0]  idx, last;
  logic [PCW-1:0] polls;
  logic [WCW-1:0] waitc;
  logic        len_ok, xfer, desc;

  assign len_ok = (req_len == 4'd1) || (req_len == 4'd2) || (req_len == 4'd4) ||
                  (req_len == 4'd6) || (req_len == 4'd8);

  always_comb begin
    case (len_q)
      4'd4:    last = 2'd1;
      4'd6:    last = 2'd2;
      4'd8:    last = 2'd3;
      default: last = 2'd0;
    endcase
  end

  assign desc   = last[1];
  assign busy   = (st != S_IDLE);
  assign bus_wr = (st == S_OPEN) || (st == S_WDAT) || (st == S_CMD) || (st == S_CLOSE);
  assign bus_rd = (st == S_POLL) || (st == S_RDAT);
  assign xfer   = (bus_wr || bus_rd) && bus_ready;

  always_comb begin
    case (st)
      S_OPEN, S_CLOSE: bus_addr = A_WIN;
      S_CMD, S_POLL:   bus_addr = A_CMD;
      S_WDAT, S_RDAT:  bus_addr = A_DATA + {3'd0, idx};
      default:         bus_addr = 5'd0;
    endcase
  end

  always_comb begin
    case (st)
      S_OPEN:  bus_wdata = {page_q, 8'h01};
      S_CLOSE: bus_wdata = {page_q, 8'h00};
      S_CMD:   bus_wdata = {reg_q, 6'd0, wr_q ? 2'b01 : 2'b10};
      S_WDAT:  bus_wdata = (len_q == 4'd1) ? {8'h00, wdata_q[7:0]} : wdata_q[{idx, 4'b0000} +: 16];
      default: bus_wdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wr_q      <= 1'b0;
      page_q    <= 8'h00;
      reg_q     <= 8'h00;
      len_q     <= 4'd0;
      wdata_q   <= 64'd0;
      idx       <= 2'd0;
      polls     <= '0;
      waitc     <= '0;
      done      <= 1'b0;
      len_err   <= 1'b0;
      timeout   <= 1'b0;
      rsp_rdata <= 64'd0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          timeout <= 1'b0;
          if (!len_ok) begin
            done    <= 1'b1;
            len_err <= 1'b1;
          end else begin
            len_err   <= 1'b0;
            wr_q      <= req_write;
            page_q    <= req_page;
            reg_q     <= req_reg;
            len_q     <= req_len;
            wdata_q   <= req_wdata;
            rsp_rdata <= 64'd0;
            idx       <= 2'd0;
            st        <= S_OPEN;
          end
        end
        S_OPEN: if (xfer) st <= wr_q ? S_WDAT : S_CMD;
        S_WDAT: if (xfer) begin
          if (idx == last) st <= S_CMD;
          else idx <= idx + 2'd1;
        end
        S_CMD: if (xfer) begin
          polls <= '0;
          st    <= S_POLL;
        end
        S_POLL: if (xfer) begin
          if (bus_rdata[1:0] == 2'b00) begin
            if (wr_q) st <= S_CLOSE;
            else begin
              idx <= desc ? last : 2'd0;
              st  <= S_RDAT;
            end
          end else if (polls == PCW'(POLL_LIMIT - 1)) begin
            timeout <= 1'b1;
            st      <= S_CLOSE;
          end else begin
            polls <= polls + 1'b1;
            waitc <= '0;
            st    <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (waitc == WCW'(WAIT_CYCLES - 1)) st <= S_POLL;
          else waitc <= waitc + 1'b1;
        end
        S_RDAT: if (xfer) begin
          if (len_q == 4'd1) rsp_rdata[7:0] <= bus_rdata[7:0];
          else rsp_rdata[{idx, 4'b0000} +: 16] <= bus_rdata;
          if (desc) begin
            if (idx == 2'd0) st <= S_CLOSE;
            else idx <= idx - 2'd1;
          end else begin
            if (idx == last) st <= S_CLOSE;
            else idx <= idx + 2'd1;
          end
        end
        S_CLOSE: if (xfer) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module paged_reg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [3:0]  req_len,
  input logic        busy,
  input logic        done,
  input logic        len_err,
  input logic        timeout,
  input logic [4:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        bus_ready
);
  logic bad_len;
  assign bad_len = !((req_len == 4'd1) || (req_len == 4'd2) || (req_len == 4'd4) ||
                     (req_len == 4'd6) || (req_len == 4'd8));

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R11

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && !bus_ready |=>
      bus_wr == $past(bus_wr) && bus_rd == $past(bus_rd) &&
      $stable(bus_addr) && $stable(bus_wdata)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_wr && !bus_rd); // R2

  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> (bus_addr == 5'd16 || bus_addr == 5'd17 ||
                            (bus_addr >= 5'd24 && bus_addr <= 5'd27))); // R3

  AST_CMD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 5'd17 |->
      bus_wdata[7:2] == 6'd0 && (bus_wdata[1:0] == 2'b01 || bus_wdata[1:0] == 2'b10)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_BAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && bad_len |=> done && len_err && !busy); // R2

  AST_TIMEOUT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !(bus_rd && bus_addr >= 5'd24)); // R7
endmodule

bind paged_reg_seq paged_reg_seq_chk i_chk (.*);

// File: tb/test_paged_reg_seq.sv
module test_paged_reg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int POLLS = 5;
  localparam int WAITC = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_page = 8'h00;
  logic [7:0]  req_reg = 8'h00;
  logic [3:0]  req_len = 4'd0;
  logic [63:0] req_wdata = 64'd0;
  logic        busy, done, len_err, timeout;
  logic [63:0] rsp_rdata;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_rdata = 16'h0000;
  logic        bus_ready = 1'b0;

  paged_reg_seq #(.POLL_LIMIT(POLLS), .WAIT_CYCLES(WAITC)) i_paged_reg_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] dmem [4];
  int busy_left = 0;
  int lat = 0;
  int n_log = 0;
  logic        lg_wr   [64];
  logic [4:0]  lg_addr [64];
  logic [15:0] lg_data [64];
  int          lg_cyc  [64];
  int n_exp = 0;
  logic        ex_wr   [64];
  logic [4:0]  ex_addr [64];
  logic [15:0] ex_data [64];

  always @(negedge clk) begin
    if (bus_ready) bus_ready = 1'b0;
    else if (bus_wr || bus_rd) begin
      if (lat < 1) lat = lat + 1;
      else begin
        lat = 0;
        if (bus_rd) begin
          if (bus_addr == 5'd17) begin
            bus_rdata = (busy_left > 0) ? 16'h0002 : 16'h0000;
            if (busy_left > 0) busy_left = busy_left - 1;
          end else if (bus_addr >= 5'd24 && bus_addr <= 5'd27) bus_rdata = dmem[bus_addr - 5'd24];
          else bus_rdata = 16'hDEAD;
        end
        if (n_log < 64) begin
          lg_wr[n_log] = bus_wr;
          lg_addr[n_log] = bus_addr;
          lg_data[n_log] = bus_wr ? bus_wdata : bus_rdata;
          lg_cyc[n_log] = cyc;
          n_log = n_log + 1;
        end
        bus_ready = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic exp_add(input logic w, input logic [4:0] a, input logic [15:0] d);
    ex_wr[n_exp] = w; ex_addr[n_exp] = a; ex_data[n_exp] = d;
    n_exp++;
  endtask

  task automatic cmp_log(input string req);
    check(n_log == n_exp, req, "access count", 64'(n_log), 64'(n_exp));
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      check(lg_wr[i] == ex_wr[i] && lg_addr[i] == ex_addr[i] && (!ex_wr[i] || lg_data[i] == ex_data[i]),
            req, $sformatf("access %0d {wr,addr,data}", i),
            {43'd0, lg_wr[i], lg_addr[i], lg_data[i]}, {43'd0, ex_wr[i], ex_addr[i], ex_data[i]});
    end
  endtask

  task automatic start_req(input logic w, input logic [7:0] pg, input logic [7:0] rg,
                           input logic [3:0] ln, input logic [63:0] wd);
    n_log = 0; n_exp = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_page = pg; req_reg = rg; req_len = ln; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(done == 1'b1, req, "done seen", 64'(done), 64'd1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, req, "done one cycle, idle", {62'd0, done, busy}, 64'd0);
  endtask

  function automatic int nwords(input int ln);
    return (ln <= 2) ? 1 : ln / 2;
  endfunction

  task automatic t_reset;
    check(busy == 0 && done == 0 && bus_wr == 0 && bus_rd == 0, "R1", "reset state",
          {60'd0, busy, done, bus_wr, bus_rd}, 64'd0);
  endtask

  task automatic t_write(input int ln, input logic [63:0] wd);
    int nw = nwords(ln);
    busy_left = 1;
    start_req(1'b1, 8'h34, 8'h5A, 4'(ln), wd);
    check(busy == 1'b1, "R1", "busy after accept", 64'(busy), 64'd1);
    wait_done("R10");
    exp_add(1, 5'd16, 16'h3401);
    for (int k = 0; k < nw; k++)
      exp_add(1, 5'(24 + k), (ln == 1) ? {8'h00, wd[7:0]} : wd[16*k +: 16]);
    exp_add(1, 5'd17, 16'h5A01);
    exp_add(0, 5'd17, 16'h0);
    exp_add(0, 5'd17, 16'h0);
    exp_add(1, 5'd16, 16'h3400);
    cmp_log($sformatf("R4 write len %0d", ln));
    check(timeout == 0 && len_err == 0, "R6", "write flags", {62'd0, timeout, len_err}, 64'd0);
  endtask

  task automatic t_read(input int ln, input int nbusy);
    int nw = nwords(ln);
    logic [63:0] er = 64'd0;
    int p0 = -1;
    dmem[0] = 16'h1A2B; dmem[1] = 16'h3C4D; dmem[2] = 16'h5E6F; dmem[3] = 16'h7081;
    busy_left = nbusy;
    start_req(1'b0, 8'hC3, 8'h2E, 4'(ln), 64'hFFFF_FFFF_FFFF_FFFF);
    wait_done("R10");
    exp_add(1, 5'd16, 16'hC301);
    exp_add(1, 5'd17, 16'h2E02);
    for (int k = 0; k <= nbusy; k++) exp_add(0, 5'd17, 16'h0);
    if (nw >= 3) for (int k = nw - 1; k >= 0; k--) exp_add(0, 5'(24 + k), 16'h0);
    else for (int k = 0; k < nw; k++) exp_add(0, 5'(24 + k), 16'h0);
    exp_add(1, 5'd16, 16'hC300);
    cmp_log($sformatf("R8 R5 read len %0d", ln));
    if (ln == 1) er[7:0] = dmem[0][7:0];
    else for (int k = 0; k < nw; k++) er[16*k +: 16] = dmem[k];
    check(rsp_rdata == er, "R9", $sformatf("read data len %0d", ln), rsp_rdata, er);
    for (int i = 0; i < n_log; i++) begin
      if (!lg_wr[i] && lg_addr[i] == 5'd17) begin
        if (p0 >= 0)
          check(lg_cyc[i] - p0 >= WAITC, "R6", "poll spacing", 64'(lg_cyc[i] - p0), 64'(WAITC));
        p0 = lg_cyc[i];
      end
    end
  endtask

  task automatic t_timeout(input logic w);
    busy_left = 1000;
    start_req(w, 8'h07, 8'h11, 4'd4, 64'h0000_0000_BEEF_CAFE);
    wait_done("R7");
    exp_add(1, 5'd16, 16'h0701);
    if (w) begin
      exp_add(1, 5'd24, 16'hCAFE);
      exp_add(1, 5'd25, 16'hBEEF);
      exp_add(1, 5'd17, 16'h1101);
    end else exp_add(1, 5'd17, 16'h1102);
    for (int k = 0; k < POLLS; k++) exp_add(0, 5'd17, 16'h0);
    exp_add(1, 5'd16, 16'h0700);
    cmp_log(w ? "R7 write timeout" : "R7 read timeout");
    check(timeout == 1'b1, "R7", "timeout flag", 64'(timeout), 64'd1);
    if (!w) check(rsp_rdata == 64'd0, "R7", "read data on timeout", rsp_rdata, 64'd0);
    busy_left = 0;
  endtask

  task automatic t_badlen(input int ln);
    start_req(1'b0, 8'h01, 8'h02, 4'(ln), 64'd0);
    check(done == 1'b1 && len_err == 1'b1 && busy == 1'b0, "R2", $sformatf("reject len %0d", ln),
          {61'd0, done, len_err, busy}, 64'd6);
    repeat (10) @(negedge clk);
    check(n_log == 0, "R2", "no bus access", 64'(n_log), 64'd0);
  endtask

  task automatic t_ignore_busy;
    busy_left = 0;
    dmem[0] = 16'h0042;
    start_req(1'b0, 8'h22, 8'h33, 4'd2, 64'd0);
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_page = 8'h99; req_len = 4'd2;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R1");
    exp_add(1, 5'd16, 16'h2201);
    exp_add(1, 5'd17, 16'h3302);
    exp_add(0, 5'd17, 16'h0);
    exp_add(0, 5'd24, 16'h0);
    exp_add(1, 5'd16, 16'h2200);
    cmp_log("R1 request while busy");
    n_log = 0;
    repeat (20) @(negedge clk);
    check(n_log == 0, "R1", "no later access", 64'(n_log), 64'd0);
    check(rsp_rdata == 64'h42, "R1", "data of accepted read", rsp_rdata, 64'h42);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_write(8, 64'h8888_7777_6666_5555);
    t_write(1, 64'h0000_0000_0000_12AB);
    t_write(6, 64'h0000_CCCC_BBBB_AAAA);
    t_read(8, 2);
    t_read(6, 0);
    t_read(4, 1);
    t_read(2, 0);
    t_read(1, 0);
    t_timeout(1'b0);
    t_timeout(1'b1);
    t_badlen(3);
    t_badlen(0);
    t_badlen(9);
    t_ignore_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule